// File: doc/BRIEF.md
# Two-Stage Debug Observation Multiplexer

This block drives a group of debug observation lines from a large set of internal signals. Each output line has its own pair of selectors. The first stage picks one bit from a 128-wide core-domain bus. The second stage either forwards that core bit or replaces it with one bit from a 32-wide wakeup-domain bus. A second-stage selector of zero forwards the core choice. Any other value picks the wakeup bit with that index. The chosen bits are registered before they reach the output pins.

Both selector banks sit behind a simple synchronous register port. A write takes effect at a rising clock edge. Read data is a combinational function of the address. Each 32-bit word holds the selectors for one even output and the odd output that follows it. Software fills in the two banks, and then the debug lines show the chosen signals with one cycle of delay.

Top module: `dbg_obs_mux`

## Requirements
- R1: During reset and after it, every selector field reads 0 and `dbg_o` is 0. After the first clock edge out of reset, every output line shows core bit 0.
- R2: When the wakeup selector of output n is 0, `dbg_o[n]` takes the value of `core_i[c]` one clock later, where c is the core selector of output n.
- R3: When the wakeup selector of output n is a nonzero value s, `dbg_o[n]` takes the value of `wkup_i[s]` one clock later. `wkup_i[0]` never reaches an output.
- R4: The core bank holds 9 words at byte offsets 0x420 + 4k, for k = 0 to 8. Word k holds the core selector of output 2k in bits [6:0] and the core selector of output 2k+1 in bits [22:16].
- R5: The wakeup bank holds 9 words at byte offsets 0x500 + 4k, for k = 0 to 8. Word k holds the wakeup selector of output 2k in bits [4:0] and the wakeup selector of output 2k+1 in bits [20:16].
- R6: A read of a mapped word returns the selector fields that were last written to it. All bits outside those fields read as 0. `rdata_o` follows `addr_i` in the same cycle.
- R7: A read of an unmapped or misaligned offset (`addr_i[1:0]` not 0) returns 0. A write to such an offset changes no selector.
- R8: The outputs are registered. A change on `core_i`, `wkup_i` or a selector is not visible on `dbg_o` before the next rising edge and is visible after it.
- R9: When `we_i` is low, no selector changes, whatever values `addr_i` and `wdata_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 12 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| core_i | input | 128 | Core-domain observable signals |
| wkup_i | input | 32 | Wakeup-domain observable signals |
| dbg_o | output | 18 | Registered debug observation lines |

## Verification
The assertions check four things on every cycle: each output line follows the source that its selector pair names, one clock later; reserved read bits and unmapped reads stay at zero; the two banks never decode the same address; and the selectors hold whenever no write is strobed. Some behaviours can only be shown by the bench's scenarios. These are the bit positions of the fields inside each word, the pairing of each word with its two outputs, the value seen right after reset, and the fact that stray writes to neighbouring or misaligned offsets leave every selector unchanged. The bench sweeps every core and wakeup selector value across all eighteen lanes and compares each output against an arithmetic model.

// File: rtl/dbg_obs_pkg.sv
package dbg_obs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HI_LSB = 16;  // bit position of the odd output's field

  function automatic int unsigned pair_regs(input int unsigned n_out);
    return (n_out + 1) / 2;
  endfunction
endpackage

// File: rtl/dbg_obs_regbank.sv
module dbg_obs_regbank
  import dbg_obs_pkg::*;
#(
  parameter int unsigned NUM_OUT = 18,
  parameter int unsigned SEL_W   = 7,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BASE    = 32'h420
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     hit_o,
  output logic [NUM_OUT*SEL_W-1:0] sel_o
);
  localparam int unsigned NUM_REG = pair_regs(NUM_OUT);
  localparam int unsigned IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
  localparam logic [DATA_W-1:0] FIELD = DATA_W'((64'd1 << SEL_W) - 64'd1);
  localparam logic [DATA_W-1:0] MASK  = FIELD | (FIELD << HI_LSB);

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  sel_q [2*NUM_REG];
  logic              wdata_unused;

  assign off   = addr_i - ADDR_W'(BASE);
  assign idx   = off[2 +: IDX_W];
  assign hit_o = (addr_i >= ADDR_W'(BASE)) && (off[1:0] == 2'b00)
              && (off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REG));
  assign wdata_unused = ^{wdata_i[DATA_W-1:HI_LSB+SEL_W], wdata_i[HI_LSB-1:SEL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 2*NUM_REG; k++) sel_q[k] <= '0;
    end else if (we_i && hit_o) begin
      for (int k = 0; k < NUM_REG; k++) begin
        if (idx == IDX_W'(k)) begin
          sel_q[2*k]   <= wdata_i[SEL_W-1:0];
          sel_q[2*k+1] <= wdata_i[HI_LSB +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_o) begin
      for (int k = 0; k < NUM_REG; k++) begin
        if (idx == IDX_W'(k)) begin
          rdata_o[SEL_W-1:0]       = sel_q[2*k];
          rdata_o[HI_LSB +: SEL_W] = sel_q[2*k+1];
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_sel
    assign sel_o[n*SEL_W +: SEL_W] = sel_q[n];
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~MASK) == '0);  // R6
  AST_MISS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0);  // R7
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sel_o));  // R9
endmodule

// File: rtl/dbg_obs_lane.sv
module dbg_obs_lane #(
  parameter int unsigned CORE_W = 128,
  parameter int unsigned WKUP_W = 32,
  localparam int unsigned CSEL_W = $clog2(CORE_W),
  localparam int unsigned WSEL_W = $clog2(WKUP_W)
) (
  input  logic [CORE_W-1:0] core_i,
  input  logic [WKUP_W-1:0] wkup_i,
  input  logic [CSEL_W-1:0] core_sel_i,
  input  logic [WSEL_W-1:0] wkup_sel_i,
  output logic              obs_o
);
  logic core_bit;

  assign core_bit = core_i[core_sel_i];
  // zero in the second stage forwards the core choice
  assign obs_o = (wkup_sel_i == '0) ? core_bit : wkup_i[wkup_sel_i];
endmodule

// File: rtl/dbg_obs_mux.sv
module dbg_obs_mux
  import dbg_obs_pkg::*;
#(
  parameter int unsigned NUM_OUT   = 18,
  parameter int unsigned CORE_W    = 128,
  parameter int unsigned WKUP_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CORE_BASE = 32'h420,
  parameter int unsigned WKUP_BASE = 32'h500
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [CORE_W-1:0]  core_i,
  input  logic [WKUP_W-1:0]  wkup_i,
  output logic [NUM_OUT-1:0] dbg_o
);
  localparam int unsigned CSEL_W = $clog2(CORE_W);
  localparam int unsigned WSEL_W = $clog2(WKUP_W);

  logic [DATA_W-1:0]         c_rdata, w_rdata;
  logic                      c_hit, w_hit;
  logic [NUM_OUT*CSEL_W-1:0] c_sel;
  logic [NUM_OUT*WSEL_W-1:0] w_sel;
  logic [NUM_OUT-1:0]        obs_d, dbg_q;

  dbg_obs_regbank #(
    .NUM_OUT(NUM_OUT), .SEL_W(CSEL_W), .ADDR_W(ADDR_W), .BASE(CORE_BASE)
  ) u_core_bank (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o(c_rdata), .hit_o(c_hit), .sel_o(c_sel)
  );

  dbg_obs_regbank #(
    .NUM_OUT(NUM_OUT), .SEL_W(WSEL_W), .ADDR_W(ADDR_W), .BASE(WKUP_BASE)
  ) u_wkup_bank (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o(w_rdata), .hit_o(w_hit), .sel_o(w_sel)
  );

  assign rdata_o = c_rdata | w_rdata;  // banks decode disjoint ranges

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    dbg_obs_lane #(.CORE_W(CORE_W), .WKUP_W(WKUP_W)) u_lane (
      .core_i,
      .wkup_i,
      .core_sel_i(c_sel[n*CSEL_W +: CSEL_W]),
      .wkup_sel_i(w_sel[n*WSEL_W +: WSEL_W]),
      .obs_o     (obs_d[n])
    );

    AST_CORE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_sel[n*WSEL_W +: WSEL_W] == '0)
        |=> dbg_o[n] == $past(core_i[c_sel[n*CSEL_W +: CSEL_W]]));  // R2
    AST_WKUP_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_sel[n*WSEL_W +: WSEL_W] != '0)
        |=> dbg_o[n] == $past(wkup_i[w_sel[n*WSEL_W +: WSEL_W]]));  // R3
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbg_q <= '0;
    else         dbg_q <= obs_d;
  end

  assign dbg_o = dbg_q;

  AST_BANK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_hit && w_hit));  // R4
endmodule

// File: tb/dbg_obs_mux_bench.sv
module dbg_obs_mux_bench;
  localparam int NO = 18;
  localparam logic [11:0] CB = 12'h420;
  localparam logic [11:0] WB = 12'h500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] core = '0;
  logic [31:0]  wkup = '0;
  logic [NO-1:0] dbg;

  int checks = 0;
  int fails  = 0;
  logic [6:0] csel [NO];
  logic [4:0] wsel [NO];

  always #10 clk = ~clk;  // 50 MHz

  dbg_obs_mux u_dbg_obs_mux (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .core_i(core), .wkup_i(wkup), .dbg_o(dbg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] exp_dbg();
    logic [NO-1:0] r;
    for (int n = 0; n < NO; n++)
      r[n] = (wsel[n] == 0) ? core[csel[n]] : wkup[wsel[n]];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] r = '0;
    if (a[1:0] == 2'b00 && a >= CB && a < CB + 12'd36) begin
      r[6:0]   = csel[2*((a - CB) >> 2)];
      r[22:16] = csel[2*((a - CB) >> 2) + 1];
    end else if (a[1:0] == 2'b00 && a >= WB && a < WB + 12'd36) begin
      r[4:0]   = wsel[2*((a - WB) >> 2)];
      r[20:16] = wsel[2*((a - WB) >> 2) + 1];
    end
    return r;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a[1:0] == 2'b00 && a >= CB && a < CB + 12'd36) begin
      csel[2*((a - CB) >> 2)]     = d[6:0];
      csel[2*((a - CB) >> 2) + 1] = d[22:16];
    end else if (a[1:0] == 2'b00 && a >= WB && a < WB + 12'd36) begin
      wsel[2*((a - WB) >> 2)]     = d[4:0];
      wsel[2*((a - WB) >> 2) + 1] = d[20:16];
    end
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic drive(input string req, input logic [127:0] c, input logic [31:0] w);
    @(negedge clk);
    core = c; wkup = w;
    @(negedge clk);
    chk(req, 32'(dbg), 32'(exp_dbg()));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(64'd20 * 64'd200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < NO; n++) begin csel[n] = '0; wsel[n] = '0; end
    core = rnd128();
    wkup = $urandom;
    #35;
    // R1: reset state
    chk("R1 dbg in reset", 32'(dbg), 32'h0);
    for (int k = 0; k < 9; k++) begin
      addr = CB + 12'(4*k); #1; chk("R1 core reg reset", rdata, 32'h0);
      addr = WB + 12'(4*k); #1; chk("R1 wkup reg reset", rdata, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    core = 128'h1;
    @(negedge clk);
    chk("R1 core bit 0 after reset", 32'(dbg), 32'((1 << NO) - 1));

    // R2/R4: sweep every core selector over all lanes
    for (int v = 0; v < 128; v++) begin
      for (int k = 0; k < 9; k++) begin
        logic [31:0] d;
        d = '0;
        d[6:0]   = 7'((v + 10*k) % 128);
        d[22:16] = 7'((v + 10*k + 69) % 128);
        wr(CB + 12'(4*k), d);
      end
      drive("R2 R4 core sweep", rnd128(), $urandom);
      drive("R2 R4 core sweep", ~core, ~wkup);
    end

    // R6: readback with every bit set
    for (int k = 0; k < 9; k++) begin
      wr(CB + 12'(4*k), 32'hFFFF_FFFF);
      wr(WB + 12'(4*k), 32'hFFFF_FFFF);
      rd_chk("R6 core readback", CB + 12'(4*k));
      chk("R6 core field mask", rdata, 32'h007F_007F);
      rd_chk("R6 wkup readback", WB + 12'(4*k));
      chk("R6 wkup field mask", rdata, 32'h001F_001F);
    end

    // R3/R5: sweep every wakeup selector over all lanes
    for (int s = 0; s < 32; s++) begin
      for (int k = 0; k < 9; k++) begin
        logic [31:0] d;
        d = '0;
        d[4:0]   = 5'((s + 3*k) % 32);
        d[20:16] = 5'((s + 3*k + 17) % 32);
        wr(WB + 12'(4*k), d);
        d[6:0]   = 7'((s * 4 + k) % 128);
        d[22:16] = 7'((s * 4 + k + 50) % 128);
        wr(CB + 12'(4*k), d);
      end
      drive("R3 R5 wkup sweep", rnd128(), $urandom);
      drive("R3 R5 wkup sweep", rnd128(), $urandom);
      drive("R3 wkup bit 0 hidden", '0, 32'h1);
      rd_chk("R5 wkup readback", WB + 12'(4*(s % 9)));
    end

    // R7: unmapped and misaligned accesses
    begin
      logic [11:0] bad [9] = '{12'h41C, 12'h444, 12'h421, 12'h422, 12'h4FC,
                               12'h524, 12'h502, 12'h000, 12'hFFC};
      for (int i = 0; i < 9; i++) begin
        wr(bad[i], 32'hFFFF_FFFF);
        @(negedge clk); addr = bad[i]; #1;
        chk("R7 unmapped read zero", rdata, 32'h0);
      end
      for (int k = 0; k < 9; k++) begin
        rd_chk("R7 core untouched", CB + 12'(4*k));
        rd_chk("R7 wkup untouched", WB + 12'(4*k));
      end
      drive("R7 outputs unchanged", rnd128(), $urandom);
    end

    // R9: no write when the strobe is low
    @(negedge clk);
    addr = CB + 12'd8; wdata = 32'h0055_0033; we = 1'b0;
    @(negedge clk); @(negedge clk);
    rd_chk("R9 no write without strobe", CB + 12'd8);
    @(negedge clk);
    addr = WB + 12'd16; wdata = 32'h0011_0007;
    @(negedge clk);
    rd_chk("R9 no write without strobe", WB + 12'd16);

    // R8: one-clock latency
    for (int n = 0; n < NO; n++) wsel[n] = '0;
    for (int k = 0; k < 9; k++) wr(WB + 12'(4*k), 32'h0);
    drive("R8 settle", rnd128(), $urandom);
    for (int i = 0; i < 4; i++) begin
      logic [NO-1:0] old;
      old = exp_dbg();
      @(negedge clk);
      core = ~core;
      #1;
      chk("R8 no change before edge", 32'(dbg), 32'(old));
      @(negedge clk);
      chk("R8 change after edge", 32'(dbg), 32'(exp_dbg()));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule